// File: doc/BRIEF.md
# Read Capture Enable Timer

This block decides, for each byte lane of a memory read path, the one clock cycle in which the lane's input buffer is opened after a read command, and it captures one strobe sample per lane in that cycle. A read-issue strobe loads a countdown with the roundtrip time of the addressed rank. When the countdown expires, every lane starts its own countdown of a whole-cycle coarse delay plus the upper bits of its fine phase code. The lower six bits of the phase code pick one of 64 sub-cycle slots from an oversampled strobe input. Raising the phase code by 64 therefore moves the window by exactly one cycle, the same as raising the coarse delay by one.

Training firmware sets the per-rank roundtrip values, the per-lane coarse delays and the phase codes, issues reads and reads back one result bit per lane after the done pulse. It then sweeps the settings to find the strobe edge. A read issued while an earlier one is still in flight cancels the earlier one and restarts the timing.

Top module: `rd_capture_timer`

## Requirements
- R1: After reset, all lane enables, all result bits and the done output are 0, and every rank's roundtrip register holds 55.
- R2: A write with `rt_we` high sets the roundtrip register chosen by `rt_wsel` to `rt_wdata`. A read uses the register chosen by `rd_rank` at the issue edge, and the other ranks keep their values.
- R3: If `rd_issue` is sampled high at clock edge E, lane l's `buf_en[l]` is high for exactly one cycle, the cycle that follows edge E+RT+1+D_l. RT is the rank's roundtrip and D_l = coarse_l + phase_l[8:6]. A roundtrip of 0 follows the same formula.
- R4: A phase code of p+64 with coarse delay c opens the window in the same cycle as a phase code of p with coarse delay c+1.
- R5: The result bit of lane l is the value of `dqs_os[l*64 + phase_l[5:0]]` during lane l's enable cycle.
- R6: `rd_done` is high for one cycle, the cycle after edge E+RT+Dmax+3, where Dmax is the largest D_l. All result bits take their new values on that same edge.
- R7: Between done pulses `rd_result` does not change, even when a new read is issued.
- R8: A `rd_issue` that arrives while an earlier read is in flight cancels that read. The cancelled read produces no done pulse, and all timing follows the new issue edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rt_we | input | 1 | Roundtrip register write enable |
| rt_wsel | input | RK_W | Rank whose roundtrip register is written |
| rt_wdata | input | RT_W | Roundtrip value in cycles |
| rd_issue | input | 1 | Read command strobe |
| rd_rank | input | RK_W | Rank addressed by the read |
| coarse_dly | input | LANES*CD_W | Per-lane whole-cycle delay |
| phase_code | input | LANES*PH_W | Per-lane phase code, 1/64-cycle units |
| dqs_os | input | LANES*64 | Oversampled strobe levels, 64 slots per lane per cycle |
| buf_en | output | LANES | Per-lane input-buffer enable |
| rd_result | output | LANES | Per-lane sampled strobe bit |
| rd_done | output | 1 | Pulse marking the result update |

## Verification
The hardest situation to reach is a restart: a second issue has to land while the countdown is still running, and no done pulse may appear for the cancelled read. The bench sets a long roundtrip, issues a read, and waits a few cycles while it checks that enables and done stay low. It then issues a read to the other rank and checks the timing against the second edge only. The phase carry of R4 is reached with two lanes whose settings differ in coarse delay and phase code but should open together. Those lanes are checked against each other in the same read.

// File: rtl/rcet_pkg.sv
package rcet_pkg;
    localparam int SLOTS     = 64;
    localparam int SLOT_W    = 6;
    localparam int RT_RESET  = 55;
endpackage

// File: rtl/rcet_rt_bank.sv
module rcet_rt_bank #(
    parameter int RANKS = 2,
    parameter int RT_W  = 8,
    localparam int RK_W = (RANKS > 1) ? $clog2(RANKS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [RK_W-1:0] wsel,
    input  logic [RT_W-1:0] wdata,
    input  logic [RK_W-1:0] rsel,
    output logic [RT_W-1:0] rdata
);
    import rcet_pkg::*;

    logic [RANKS-1:0][RT_W-1:0] rt_d, rt_q;

    always_comb begin
        rt_d = rt_q;
        if (we && (int'(wsel) < RANKS)) begin
            rt_d[wsel] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < RANKS; r++) rt_q[r] <= RT_W'(RT_RESET);
        end else begin
            rt_q <= rt_d;
        end
    end

    assign rdata = (int'(rsel) < RANKS) ? rt_q[rsel] : '0;

    // R2: registers change only when written
    assert_hold_unwritten_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(rt_q));
endmodule

// File: rtl/rcet_lane.sv
module rcet_lane #(
    parameter int CD_W = 4,
    parameter int PH_W = 9,
    localparam int HI_W = PH_W - rcet_pkg::SLOT_W,
    localparam int LD_W = ((CD_W > HI_W) ? CD_W : HI_W) + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        abort,
    input  logic [CD_W-1:0]             coarse,
    input  logic [PH_W-1:0]             phase,
    input  logic [rcet_pkg::SLOTS-1:0]  dqs,
    output logic                        en,
    output logic                        busy,
    output logic                        smp
);
    import rcet_pkg::*;

    typedef struct packed {
        logic [LD_W-1:0]   cnt;
        logic [SLOT_W-1:0] slot;
        logic              arm;
        logic              smp;
    } lane_st_t;

    lane_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (abort) begin
            s_d.arm = 1'b0;
        end else if (start) begin
            s_d.cnt  = LD_W'(coarse) + LD_W'(phase[PH_W-1:SLOT_W]);
            s_d.slot = phase[SLOT_W-1:0];
            s_d.arm  = 1'b1;
        end else if (s_q.arm) begin
            if (s_q.cnt == '0) begin
                s_d.smp = dqs[s_q.slot];
                s_d.arm = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en   = s_q.arm && (s_q.cnt == '0);
    assign busy = s_q.arm;
    assign smp  = s_q.smp;

    // R3: the window lasts a single cycle
    assert_single_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> !en);

    // R3: lane delay counts down one per cycle while armed
    assert_lane_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !en && !abort && !start) |=> (busy && s_q.cnt == $past(s_q.cnt) - 1'b1));
endmodule

// File: rtl/rd_capture_timer.sv
module rd_capture_timer #(
    parameter int LANES = 4,
    parameter int RANKS = 2,
    parameter int RT_W  = 8,
    parameter int CD_W  = 4,
    parameter int PH_W  = 9,
    localparam int RK_W = (RANKS > 1) ? $clog2(RANKS) : 1,
    localparam int OS   = rcet_pkg::SLOTS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rt_we,
    input  logic [RK_W-1:0]        rt_wsel,
    input  logic [RT_W-1:0]        rt_wdata,
    input  logic                   rd_issue,
    input  logic [RK_W-1:0]        rd_rank,
    input  logic [LANES*CD_W-1:0]  coarse_dly,
    input  logic [LANES*PH_W-1:0]  phase_code,
    input  logic [LANES*OS-1:0]    dqs_os,
    output logic [LANES-1:0]       buf_en,
    output logic [LANES-1:0]       rd_result,
    output logic                   rd_done
);
    typedef struct packed {
        logic [RT_W-1:0]  cnt;
        logic             run;
        logic             wait_all;
        logic             done;
        logic [LANES-1:0] res;
    } top_st_t;

    top_st_t s_d, s_q;
    logic [RT_W-1:0]  rt_rd;
    logic             rt_hit;
    logic [LANES-1:0] lane_busy, lane_smp;

    rcet_rt_bank #(.RANKS(RANKS), .RT_W(RT_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rt_we),
        .wsel  (rt_wsel),
        .wdata (rt_wdata),
        .rsel  (rd_rank),
        .rdata (rt_rd)
    );

    assign rt_hit = s_q.run && (s_q.cnt == '0) && !rd_issue;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        rcet_lane #(.CD_W(CD_W), .PH_W(PH_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (rt_hit),
            .abort  (rd_issue),
            .coarse (coarse_dly[l*CD_W +: CD_W]),
            .phase  (phase_code[l*PH_W +: PH_W]),
            .dqs    (dqs_os[l*OS +: OS]),
            .en     (buf_en[l]),
            .busy   (lane_busy[l]),
            .smp    (lane_smp[l])
        );
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (rd_issue) begin
            s_d.cnt      = rt_rd;
            s_d.run      = 1'b1;
            s_d.wait_all = 1'b0;
        end else begin
            if (rt_hit) begin
                s_d.run      = 1'b0;
                s_d.wait_all = 1'b1;
            end else if (s_q.run) begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
            if (s_q.wait_all && !(|lane_busy)) begin
                s_d.done     = 1'b1;
                s_d.wait_all = 1'b0;
                s_d.res      = lane_smp;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_result = s_q.res;
    assign rd_done   = s_q.done;

    // R2: the issue loads the addressed rank's roundtrip
    assert_load_rank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issue |=> (s_q.run && s_q.cnt == $past(rt_rd)));

    // R3: countdown decrements by one per cycle
    assert_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && s_q.cnt != '0 && !rd_issue) |=> (s_q.run && s_q.cnt == $past(s_q.cnt) - 1'b1));

    // R6: done is a single-cycle pulse
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    // R7: results move only together with done
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_result) |-> rd_done);

    // R8: a new issue suppresses the done of the cancelled read
    assert_restart_nodone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issue |=> !rd_done);
endmodule

// File: tb/tb_rd_capture_timer.sv
`timescale 1ns/1ps
module tb_rd_capture_timer;
    localparam int LANES = 4;
    localparam int CD_W  = 4;
    localparam int PH_W  = 9;

    typedef struct packed {
        logic [7:0]  rt;
        logic        rk;
        logic [15:0] cd;
        logic [35:0] ph;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{8'd12, 1'b0, 16'h3210, {9'd5,   9'd70,  9'd130, 9'd0}},
        '{8'd0,  1'b1, 16'h0000, {9'd63,  9'd0,   9'd511, 9'd64}},
        '{8'd20, 1'b0, 16'hFFFF, {9'd511, 9'd511, 9'd511, 9'd511}},
        '{8'd7,  1'b1, 16'h1234, {9'd17,  9'd200, 9'd33,  9'd400}},
        '{8'd3,  1'b0, 16'h0A05, {9'd300, 9'd1,   9'd127, 9'd448}},
        '{8'd9,  1'b1, 16'h2121, {9'd1,   9'd65,  9'd128, 9'd63}}
    };

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  rt_we = 1'b0;
    logic [0:0]            rt_wsel = '0;
    logic [7:0]            rt_wdata = '0;
    logic                  rd_issue = 1'b0;
    logic [0:0]            rd_rank = '0;
    logic [LANES*CD_W-1:0] coarse_dly = '0;
    logic [LANES*PH_W-1:0] phase_code = '0;
    logic [LANES*64-1:0]   dqs_os;
    logic [LANES-1:0]      buf_en, rd_result;
    logic                  rd_done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [LANES-1:0] prev_res = '0;
    int en_seen [LANES];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic pat(int c, int l, int s);
        return ((c * 5 + s * 3 + l * 7) % 4) < 2;
    endfunction

    always_comb begin
        for (int l = 0; l < LANES; l++)
            for (int s = 0; s < 64; s++)
                dqs_os[l*64 + s] = pat(cyc, l, s);
    end

    rd_capture_timer dut (
        .clk(clk), .rst_n(rst_n), .rt_we(rt_we), .rt_wsel(rt_wsel), .rt_wdata(rt_wdata),
        .rd_issue(rd_issue), .rd_rank(rd_rank), .coarse_dly(coarse_dly),
        .phase_code(phase_code), .dqs_os(dqs_os), .buf_en(buf_en),
        .rd_result(rd_result), .rd_done(rd_done)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_rt(int rk, int val);
        @(negedge clk);
        rt_we = 1'b1; rt_wsel = 1'(rk); rt_wdata = 8'(val);
        @(negedge clk);
        rt_we = 1'b0;
    endtask

    task automatic issue(int rk, logic [15:0] cd, logic [35:0] ph, output int c0);
        @(negedge clk);
        rd_rank = 1'(rk); coarse_dly = cd; phase_code = ph; rd_issue = 1'b1;
        @(posedge clk);
        #1 c0 = cyc;
        @(negedge clk);
        rd_issue = 1'b0;
    endtask

    // Watches one read from the negedge after its issue; checks R3, R5, R6, R7
    task automatic watch(int c0, int rt, logic [15:0] cd, logic [35:0] ph);
        int d [LANES];
        int dmax = 0;
        int en_err = 0;
        int done_err = 0;
        int hold_err = 0;
        logic [LANES-1:0] exp_res;
        for (int l = 0; l < LANES; l++) begin
            d[l] = int'(cd[l*CD_W +: CD_W]) + int'(ph[l*PH_W+6 +: 3]);
            if (d[l] > dmax) dmax = d[l];
            exp_res[l] = pat(c0 + rt + 1 + d[l], l, int'(ph[l*PH_W +: 6]));
            en_seen[l] = -1;
        end
        for (int k = 0; k <= rt + dmax + 5; k++) begin
            if (k > 0) @(negedge clk);
            for (int l = 0; l < LANES; l++) begin
                if (buf_en[l] !== ((cyc - c0) == rt + 1 + d[l])) en_err++;
                if (buf_en[l] === 1'b1 && en_seen[l] < 0) en_seen[l] = cyc - c0;
            end
            if (rd_done !== ((cyc - c0) == rt + dmax + 3)) done_err++;
            if ((cyc - c0) < rt + dmax + 3) begin
                if (rd_result !== prev_res) hold_err++;
            end else if ((cyc - c0) == rt + dmax + 3) begin
                check(rd_result === exp_res, "R5 sampled slot bits", int'(rd_result), int'(exp_res));
            end
        end
        check(en_err == 0, "R3 enable window timing", en_err, 0);
        check(done_err == 0, "R6 done pulse timing", done_err, 0);
        check(hold_err == 0, "R7 result held before done", hold_err, 0);
        prev_res = exp_res;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int c0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(buf_en === '0, "R1 enables after reset", int'(buf_en), 0);
        check(rd_result === '0, "R1 results after reset", int'(rd_result), 0);
        check(rd_done === 1'b0, "R1 done after reset", int'(rd_done), 0);
        rst_n = 1'b1;

        // R1: default roundtrip of 55 on both ranks
        issue(0, 16'h0000, 36'h0, c0);
        watch(c0, 55, 16'h0000, 36'h0);
        issue(1, 16'h0001, {9'd0, 9'd0, 9'd0, 9'd64}, c0);
        watch(c0, 55, 16'h0001, {9'd0, 9'd0, 9'd0, 9'd64});

        // Vector table: R2 per-rank roundtrip, R3/R5/R6/R7
        for (int i = 0; i < 6; i++) begin
            write_rt(int'(VEC[i].rk), int'(VEC[i].rt));
            issue(int'(VEC[i].rk), VEC[i].cd, VEC[i].ph, c0);
            watch(c0, int'(VEC[i].rt), VEC[i].cd, VEC[i].ph);
        end

        // R2: rank 0 keeps 3 after rank 1 was rewritten to 9
        issue(0, 16'h0000, 36'h0, c0);
        watch(c0, 3, 16'h0000, 36'h0);

        // R4: lane0 coarse 2 phase 5; lane1 coarse 1 phase 69
        issue(1, 16'h0012, {9'd0, 9'd0, 9'd69, 9'd5}, c0);
        watch(c0, 9, 16'h0012, {9'd0, 9'd0, 9'd69, 9'd5});
        check(en_seen[0] == en_seen[1] && en_seen[0] >= 0, "R4 phase carry equals coarse step",
              en_seen[1], en_seen[0]);

        // R8: restart while the countdown runs
        write_rt(0, 30);
        write_rt(1, 4);
        issue(0, 16'h0000, 36'h0, c0);
        begin
            int bad = 0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (buf_en !== '0 || rd_done !== 1'b0) bad++;
            end
            check(bad == 0, "R8 quiet before restart", bad, 0);
        end
        issue(1, 16'h0102, {9'd0, 9'd64, 9'd3, 9'd130}, c0);
        watch(c0, 4, 16'h0102, {9'd0, 9'd64, 9'd3, 9'd130});
        begin
            int bad = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (rd_done !== 1'b0 || buf_en !== '0) bad++;
            end
            check(bad == 0, "R8 no done from cancelled read", bad, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule